// File: doc/BRIEF.md
# Four-switch buck-boost PWM modulator

This block turns one signed demand word from an outside voltage-loop compensator into the four gate drives of a four-switch buck-boost stage. The buck leg has a high switch and a low switch, and so does the boost leg. A free-running counter sets the switching period. At the end of every period the block samples the demand and the limit inputs and picks one of four operating modes. It then computes the low-side duty of the buck leg and the low-side duty of the boost leg, clamps both to a programmable window, and lays the pulses out within the next period. A dead-time stage delays every turn-on edge, so the two switches of a leg are never driven together.

The demand is a position on a single ratio axis counted in carrier ticks, from 0 to twice the period. At the low end the block works as a pure buck. As the demand rises, the buck low-side pulse narrows until it reaches the minimum duty. The block then enters a buck-boost region in which the boost leg cuts in at the minimum duty. In that same period the buck low-side pulse is widened by a programmable offset, which stops the output from stepping. Further rise first narrows the buck pulse back to the minimum, then reorders the period so that the boost phase comes first, and finally reaches pure boost. Each mode boundary has a one-tick hysteresis band.

Top module: `fsbb_modulator`

## Requirements
- R1: While reset is low, all four gates are low and the mode output is 0. In the first carrier period after reset the buck high gate stays low for the whole period, because the buck low duty starts at the full period and the boost duty starts at 0.
- R2: The carrier counts 0 to PERIOD-1 (PERIOD = 100 by default). Demand, limits and offset are sampled only at count PERIOD-1. The new mode and duties take effect from count 0 of the following period, so the mode output changes only when the count is 0.
- R3: In buck mode (code 0) the boost low gate is off and the boost high gate is on. The buck low switch is on for counts below d2, where d2 = clamp(PERIOD - u). The buck high switch is the complement of the buck low switch.
- R4: In boost mode (code 3) the buck high gate is on and the buck low gate is off. The boost low switch is on for counts below d3, where d3 = clamp(dmin + k - x). The boost high switch is the complement of the boost low switch.
- R5: In buck-first buck-boost mode (code 1) the buck low switch is on for counts below d2 = clamp(dmin + x - k). The boost low switch is on for the last dmin counts of the period.
- R6: In boost-first buck-boost mode (code 2) the boost low switch is on for counts below d3 = clamp(dmin + k - x). The buck low switch is on for the last dmin counts of the period.
- R7: Let k = u - (PERIOD - dmin). The mode moves at most one step per period. The steps are 0→1 when k ≥ 1, 1→0 when k ≤ -1, 1→2 when k ≥ x+1, 2→1 when k ≤ x-1, 2→3 when k ≥ 2x+1, and 3→2 when k ≤ 2x-1. Otherwise the mode is held. A demand that sits on a threshold therefore never makes the mode chatter.
- R8: The demand is saturated to u in [0, 2·PERIOD]. Every computed duty is clamped to [dmin, dmax].
- R9: Each gate rises dead_cycles+1 clocks after its ideal on-state begins and falls one clock after that state ends. An ideal pulse of dead_cycles clocks or fewer is suppressed. The two gates of a leg are never high together.
- R10: The mode output encodes 0 as buck, 1 as buck-boost with the buck phase first, 2 as buck-boost with the boost phase first, and 3 as boost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| demand | input | DEM_W | Signed control demand in carrier ticks |
| duty_min | input | DW | Minimum leg duty, in ticks |
| duty_max | input | DW | Maximum leg duty, in ticks |
| bb_offset | input | DW | Buck widening offset x applied when the boost leg cuts in |
| dead_cycles | input | DT_W | Dead time, in clocks |
| gate_buck_hi | output | 1 | Buck leg high-side gate |
| gate_buck_lo | output | 1 | Buck leg low-side gate |
| gate_boost_lo | output | 1 | Boost leg low-side gate |
| gate_boost_hi | output | 1 | Boost leg high-side gate |
| mode | output | 2 | Operating mode code |

## Verification
The inputs are sampled at count PERIOD-1, so a change in the demand reaches the mode output and the pulse layout only at count 0 of the next period. That is up to PERIOD clocks after the change. A multi-step mode change takes one period for each step. The gates are registered one clock behind the ideal waveform that the count produces. Every turn-on edge then waits a further dead_cycles clocks. The bench model applies exactly these delays and compares the mode and all four gates at every falling edge. The directed checks sample mode only after whole periods have passed, which leaves time for every pending step.

// File: rtl/fsbb_pkg.sv
package fsbb_pkg;
   typedef enum logic [1:0] {
      MODE_BUCK     = 2'd0,
      MODE_BB_BUCK1 = 2'd1,
      MODE_BB_BOOST1 = 2'd2,
      MODE_BOOST    = 2'd3
   } fsbb_mode_e;
endpackage

// File: rtl/fsbb_carrier.sv
module fsbb_carrier #(
   parameter int PERIOD = 100,
   parameter int DW     = $clog2(PERIOD + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [DW-1:0] cnt,
   output logic          wrap
);
   localparam logic [DW-1:0] LAST = DW'(PERIOD - 1);

   assign wrap = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (wrap) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/fsbb_mode_duty.sv
module fsbb_mode_duty
   import fsbb_pkg::*;
#(
   parameter int PERIOD = 100,
   parameter int DW     = $clog2(PERIOD + 1),
   parameter int DEM_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wrap,
   input  logic signed [DEM_W-1:0] demand,
   input  logic [DW-1:0]           dmin,
   input  logic [DW-1:0]           dmax,
   input  logic [DW-1:0]           offs,
   output fsbb_mode_e              mode_q,
   output logic [DW-1:0]           d2_q,
   output logic [DW-1:0]           d3_q
);
   localparam int SW = DEM_W + 2;
   localparam logic signed [SW-1:0] P_S    = SW'(PERIOD);
   localparam logic signed [SW-1:0] TWOP_S = SW'(2 * PERIOD);
   localparam logic signed [SW-1:0] ONE_S  = SW'(1);
   localparam logic signed [SW-1:0] ZERO_S = '0;

   logic signed [SW-1:0] dem_s, u_s, k_s, mn_s, mx_s, x_s, x2_s;
   fsbb_mode_e           nxt;
   logic [DW-1:0]        d2_n, d3_n;

   function automatic logic [DW-1:0] clampd(input logic signed [SW-1:0] v,
                                            input logic signed [SW-1:0] lo,
                                            input logic signed [SW-1:0] hi);
      if (v < lo)      return lo[DW-1:0];
      else if (v > hi) return hi[DW-1:0];
      else             return v[DW-1:0];
   endfunction

   assign dem_s = {{2{demand[DEM_W-1]}}, demand};
   assign mn_s  = {{(SW-DW){1'b0}}, dmin};
   assign mx_s  = {{(SW-DW){1'b0}}, dmax};
   assign x_s   = {{(SW-DW){1'b0}}, offs};
   assign x2_s  = x_s + x_s;

   always_comb begin
      if (dem_s < ZERO_S)      u_s = ZERO_S;
      else if (dem_s > TWOP_S) u_s = TWOP_S;
      else                     u_s = dem_s;
   end

   assign k_s = u_s - (P_S - mn_s);

   always_comb begin
      nxt = mode_q;
      unique case (mode_q)
         MODE_BUCK:      if (k_s >= ONE_S) nxt = MODE_BB_BUCK1;
         MODE_BB_BUCK1:  if (k_s <= -ONE_S) nxt = MODE_BUCK;
                         else if (k_s >= x_s + ONE_S) nxt = MODE_BB_BOOST1;
         MODE_BB_BOOST1: if (k_s <= x_s - ONE_S) nxt = MODE_BB_BUCK1;
                         else if (k_s >= x2_s + ONE_S) nxt = MODE_BOOST;
         MODE_BOOST:     if (k_s <= x2_s - ONE_S) nxt = MODE_BB_BOOST1;
      endcase
   end

   always_comb begin
      d2_n = '0;
      d3_n = '0;
      unique case (nxt)
         MODE_BUCK:      d2_n = clampd(P_S - u_s, mn_s, mx_s);
         MODE_BB_BUCK1: begin
            d2_n = clampd(mn_s + x_s - k_s, mn_s, mx_s);
            d3_n = dmin;
         end
         MODE_BB_BOOST1: begin
            d2_n = dmin;
            d3_n = clampd(mn_s + k_s - x_s, mn_s, mx_s);
         end
         MODE_BOOST:     d3_n = clampd(mn_s + k_s - x_s, mn_s, mx_s);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_BUCK;
         d2_q   <= DW'(PERIOD);
         d3_q   <= '0;
      end else if (wrap) begin
         mode_q <= nxt;
         d2_q   <= d2_n;
         d3_q   <= d3_n;
      end
   end
endmodule

// File: rtl/fsbb_phase_gen.sv
module fsbb_phase_gen
   import fsbb_pkg::*;
#(
   parameter int PERIOD = 100,
   parameter int DW     = $clog2(PERIOD + 1)
) (
   input  logic [DW-1:0] cnt,
   input  fsbb_mode_e    mode,
   input  logic [DW-1:0] d2,
   input  logic [DW-1:0] d3,
   output logic [3:0]    ideal
);
   localparam logic [DW:0] P_E = (DW+1)'(PERIOD);

   logic [DW:0] cnt_e, tail2, tail3;
   logic        lo_a, lo_b;

   assign cnt_e = {1'b0, cnt};
   assign tail2 = P_E - {1'b0, d2};
   assign tail3 = P_E - {1'b0, d3};

   always_comb begin
      lo_a = 1'b0;
      lo_b = 1'b0;
      unique case (mode)
         MODE_BUCK:      lo_a = (cnt < d2);
         MODE_BB_BUCK1: begin
            lo_a = (cnt < d2);
            lo_b = (cnt_e >= tail3);
         end
         MODE_BB_BOOST1: begin
            lo_b = (cnt < d3);
            lo_a = (cnt_e >= tail2);
         end
         MODE_BOOST:     lo_b = (cnt < d3);
      endcase
   end

   assign ideal = {~lo_b, lo_b, lo_a, ~lo_a};
endmodule

// File: rtl/fsbb_deadband.sv
module fsbb_deadband #(
   parameter int DT_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ideal,
   input  logic [DT_W-1:0] dead,
   output logic            gate
);
   localparam logic [DT_W-1:0] RUN_MAX = '1;

   logic [DT_W-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= '0;
         gate <= 1'b0;
      end else if (ideal) begin
         gate <= (run >= dead);
         if (run != RUN_MAX) run <= run + 1'b1;
      end else begin
         run  <= '0;
         gate <= 1'b0;
      end
   end
endmodule

// File: rtl/fsbb_modulator.sv
module fsbb_modulator
   import fsbb_pkg::*;
#(
   parameter int PERIOD = 100,
   parameter int DEM_W  = 12,
   parameter int DT_W   = 4,
   parameter int DW     = $clog2(PERIOD + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [DEM_W-1:0] demand,
   input  logic [DW-1:0]           duty_min,
   input  logic [DW-1:0]           duty_max,
   input  logic [DW-1:0]           bb_offset,
   input  logic [DT_W-1:0]         dead_cycles,
   output logic                    gate_buck_hi,
   output logic                    gate_buck_lo,
   output logic                    gate_boost_lo,
   output logic                    gate_boost_hi,
   output logic [1:0]              mode
);
   localparam int NGATE = 4;

   initial begin
      assert (PERIOD >= 8) else $error("PERIOD too small");
      assert (DEM_W >= DW + 2) else $error("DEM_W cannot span twice the period");
      assert (DT_W >= 1) else $error("DT_W must be at least 1");
   end

   logic [DW-1:0]    cnt_q, d2_q, d3_q;
   logic             wrap;
   fsbb_mode_e       mode_st;
   logic [NGATE-1:0] ideal, gate;

   fsbb_carrier #(.PERIOD(PERIOD), .DW(DW)) u_carrier (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .wrap(wrap)
   );

   fsbb_mode_duty #(.PERIOD(PERIOD), .DW(DW), .DEM_W(DEM_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .demand(demand),
      .dmin(duty_min), .dmax(duty_max), .offs(bb_offset),
      .mode_q(mode_st), .d2_q(d2_q), .d3_q(d3_q)
   );

   fsbb_phase_gen #(.PERIOD(PERIOD), .DW(DW)) u_phase (
      .cnt(cnt_q), .mode(mode_st), .d2(d2_q), .d3(d3_q), .ideal(ideal)
   );

   for (genvar g = 0; g < NGATE; g++) begin : g_db
      fsbb_deadband #(.DT_W(DT_W)) u_db (
         .clk(clk), .rst_n(rst_n), .ideal(ideal[g]),
         .dead(dead_cycles), .gate(gate[g])
      );
   end

   assign gate_buck_hi  = gate[0];
   assign gate_buck_lo  = gate[1];
   assign gate_boost_lo = gate[2];
   assign gate_boost_hi = gate[3];
   assign mode          = mode_st;
endmodule

// File: rtl/fsbb_modulator_chk.sv
module fsbb_modulator_chk #(
   parameter int DW   = 7,
   parameter int DT_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [DW-1:0]   cnt,
   input logic [1:0]      mode,
   input logic            q1,
   input logic            q2,
   input logic            q3,
   input logic            q4,
   input logic [DT_W-1:0] dead
);
   // R9
   buck_pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(q1 && q2));
   // R9
   boost_pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(q3 && q4));
   // R9
   buck_hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dead != '0 && $rose(q1)) |-> !$past(q2));
   // R2
   mode_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != $past(mode)) |-> (cnt == '0));
   // R7
   mode_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != $past(mode)) |->
         (({1'b0, mode} == {1'b0, $past(mode)} + 3'd1) ||
          ({1'b0, mode} + 3'd1 == {1'b0, $past(mode)})));
   // R3
   buck_boostlo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && $past(mode) == 2'd0) |-> !q3);
   // R4
   boost_bucklo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3 && $past(mode) == 2'd3) |-> !q2);
endmodule

bind fsbb_modulator fsbb_modulator_chk #(.DW(DW), .DT_W(DT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .mode(mode),
   .q1(gate_buck_hi), .q2(gate_buck_lo), .q3(gate_boost_lo), .q4(gate_boost_hi),
   .dead(dead_cycles)
);

// File: tb/fsbb_modulator_tb.sv
`timescale 1ns/1ps
module fsbb_modulator_tb;
   localparam int P = 100;
   localparam int RUNMAX = 15;

   logic              clk = 0;
   logic              rst_n = 0;
   logic signed [11:0] demand = 12'sd40;
   logic [6:0]        dmin = 7'd5, dmax = 7'd95, offs = 7'd6;
   logic [3:0]        dead = 4'd2;
   logic              q1, q2, q3, q4;
   logic [1:0]        mode;

   int checks = 0, errors = 0;
   bit finished = 0;
   bit seen [4];
   int chatter = 0;
   bit count_chatter = 0;

   always #2.5 clk = ~clk;

   fsbb_modulator u_dut (
      .clk(clk), .rst_n(rst_n), .demand(demand), .duty_min(dmin),
      .duty_max(dmax), .bb_offset(offs), .dead_cycles(dead),
      .gate_buck_hi(q1), .gate_buck_lo(q2), .gate_boost_lo(q3),
      .gate_boost_hi(q4), .mode(mode)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference model
   int  m_cnt, m_mode, m_d2, m_d3;
   int  m_run [4];
   bit  m_g [4];

   function automatic int clampi(int v);
      if (v < int'(dmin)) return int'(dmin);
      if (v > int'(dmax)) return int'(dmax);
      return v;
   endfunction

   always @(posedge clk or negedge rst_n) begin : mdl
      bit ia, ib;
      bit id [4];
      int u, k, x, nm;
      if (!rst_n) begin
         m_cnt = 0; m_mode = 0; m_d2 = P; m_d3 = 0;
         for (int i = 0; i < 4; i++) begin m_run[i] = 0; m_g[i] = 0; end
      end else begin
         ia = 0; ib = 0;
         case (m_mode)
            0: ia = (m_cnt < m_d2);
            1: begin ia = (m_cnt < m_d2); ib = (m_cnt >= P - m_d3); end
            2: begin ib = (m_cnt < m_d3); ia = (m_cnt >= P - m_d2); end
            default: ib = (m_cnt < m_d3);
         endcase
         id[0] = !ia; id[1] = ia; id[2] = ib; id[3] = !ib;
         for (int i = 0; i < 4; i++) begin
            if (id[i]) begin
               m_g[i] = (m_run[i] >= int'(dead));
               if (m_run[i] < RUNMAX) m_run[i]++;
            end else begin
               m_run[i] = 0; m_g[i] = 0;
            end
         end
         if (m_cnt == P - 1) begin
            u = int'(demand);
            if (u < 0) u = 0;
            if (u > 2 * P) u = 2 * P;
            x = int'(offs);
            k = u - (P - int'(dmin));
            nm = m_mode;
            if (m_mode == 0 && k >= 1) nm = 1;
            else if (m_mode == 1 && k <= -1) nm = 0;
            else if (m_mode == 1 && k >= x + 1) nm = 2;
            else if (m_mode == 2 && k <= x - 1) nm = 1;
            else if (m_mode == 2 && k >= 2 * x + 1) nm = 3;
            else if (m_mode == 3 && k <= 2 * x - 1) nm = 2;
            m_mode = nm;
            case (nm)
               0: begin m_d2 = clampi(P - u); m_d3 = 0; end
               1: begin m_d2 = clampi(int'(dmin) + x - k); m_d3 = int'(dmin); end
               2: begin m_d2 = int'(dmin); m_d3 = clampi(int'(dmin) + k - x); end
               default: begin m_d2 = 0; m_d3 = clampi(int'(dmin) + k - x); end
            endcase
            m_cnt = 0;
         end else m_cnt++;
      end
   end

   // per-cycle comparison
   logic [1:0] prev_mode = 2'd0;
   always @(negedge clk) begin : cmp
      string tag;
      int act, exp;
      if (!finished) begin
         case (m_mode)
            0: tag = "R3"; 1: tag = "R5"; 2: tag = "R6"; default: tag = "R4";
         endcase
         if (dead == 0) tag = {tag, "/R9"};
         act = {q4, q3, q2, q1};
         exp = {m_g[3], m_g[2], m_g[1], m_g[0]};
         chk(tag, act, exp);
         chk("R7 mode", int'(mode), m_mode);
         if (rst_n) seen[mode] = 1;
         if (count_chatter && mode != prev_mode) chatter++;
         prev_mode = mode;
      end
   end

   task automatic wait_per(input int n);
      repeat (n * P) @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk("R1 gates in reset", {q4, q3, q2, q1}, 0);
      chk("R1 mode in reset", int'(mode), 0);
      @(posedge clk); #1;
      rst_n = 1;
   endtask

   initial begin : stim
      int hi1;
      rst_n = 0;
      repeat (4) @(negedge clk);
      chk("R1 gates in reset", {q4, q3, q2, q1}, 0);
      chk("R1 mode in reset", int'(mode), 0);
      @(posedge clk); #1;
      rst_n = 1;
      hi1 = 0;
      repeat (P - 2) begin @(negedge clk); if (q1) hi1++; end
      chk("R1 first period buck high off", hi1, 0);
      wait_per(2);

      // threshold hold from buck: no chatter
      demand = 12'sd95;
      wait_per(1);
      count_chatter = 1; chatter = 0;
      wait_per(8);
      count_chatter = 0;
      chk("R7 no chatter at threshold", chatter, 0);
      chk("R7 hold buck at k=0", int'(mode), 0);
      demand = 12'sd96;
      wait_per(3);
      chk("R7 enter buck-first", int'(mode), 1);
      demand = 12'sd95;
      wait_per(3);
      chk("R7 hysteresis keeps mode 1", int'(mode), 1);
      demand = 12'sd94;
      wait_per(2);
      chk("R7 back to buck", int'(mode), 0);

      // ramp up and down
      for (int v = 40; v <= 210; v += 5) begin demand = 12'(v); wait_per(1); end
      chk("R4 boost at high demand", int'(mode), 3);
      demand = 12'sd1000;
      wait_per(3);
      chk("R8 saturated demand in boost", int'(mode), 3);
      demand = -12'sd500;
      wait_per(4);
      chk("R8 negative demand gives buck", int'(mode), 0);
      for (int v = 210; v >= 40; v -= 7) begin demand = 12'(v); wait_per(1); end

      // zero dead time run
      demand = 12'sd40;
      dead = 4'd0;
      do_reset();
      for (int v = 60; v <= 190; v += 9) begin demand = 12'(v); wait_per(1); end
      for (int v = 190; v >= 60; v -= 11) begin demand = 12'(v); wait_per(1); end

      // narrow limits, wider dead time
      dead = 4'd3; dmin = 7'd10; dmax = 7'd60; offs = 7'd3;
      do_reset();
      for (int v = 50; v <= 200; v += 6) begin demand = 12'(v); wait_per(1); end
      wait_per(2);

      for (int i = 0; i < 4; i++) chk("R10 mode code visited", int'(seen[i]), 1);
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      #(5.0 * 150000);
      if (!finished) begin
         finished = 1;
         checks++; errors++;
         $display("FAIL R2 watchdog expired: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule